// File: doc/BRIEF.md
# Two-Class Crosspoint Cell Selector

This block is the arbitration controller at one crosspoint of a column in a crosspoint-buffered cell switch. Arbitration is distributed, so every crosspoint runs its own copy. In each cycle the selector picks at most one cell to move into the transit buffer at the next crosspoint down the column. Four kinds of source can offer a cell:

- the local high-class crosspoint buffer;
- the high-class transit buffer coming from above;
- the local low-class crosspoint buffer;
- the per-upstream-source virtual queues of the low-class transit buffer.

The downstream high and low transit buffers each send their own nearly-full backpressure signal.

The high class has strict priority over the low class. A stall from the downstream high buffer stops both classes. When the two high-class sources compete, the one whose head cell has waited longer wins. The block keeps one saturating waiting-time counter per high source for this purpose. The low class uses only the bandwidth the high class leaves over. It shares that bandwidth through a round-robin ring over the local low buffer and the virtual queues, so every low source gets a max-min fair share. The grant is returned as a one-hot vector, together with a valid bit and a class bit. The datapath uses the grant to move the cell.

Top module: `xp_cell_selector`

## Requirements
- R1: After reset the waiting-time counters are zero, no grant is issued while no request is active, and the ring starts at position 0. So with every low request active, position 0 (the local low buffer) wins first.
- R2: While `dn_hi_full` is 1, `sel_valid` is 0 and no grant bit is set, whatever the requests are.
- R3: While `hi_xp_req` or `hi_tb_req` is 1, no low grant bit is set. If `dn_hi_full` is 0, one high request is granted and `sel_class` is 1.
- R4: `dn_lo_full` blocks only low grants. High grants still go ahead while it is 1, and the ring pointer does not move during a cycle in which it blocks the low class.
- R5: When both high requests are active, the source with the larger waiting-time counter wins. If the counters are equal, the transit buffer wins.
- R6: Each high waiting-time counter rises by 1 in each cycle its request is active and not granted. It stops at 2^AGE_W-1, and it returns to 0 in any cycle its request is granted or inactive.
- R7: A low grant is allowed only when no high request is active and both backpressure inputs are 0. Ring position 0 is `lo_xp_req` and position k (1..N-1) is `lo_vq_req[k-1]`. The winner is the first requesting position at or after the pointer, going upward and wrapping around.
- R8: The ring pointer moves to the position just after the winner (wrapping N-1 to 0), and only in a cycle in which a low grant is issued.
- R9: `sel_onehot` bits [N-1:0] are the low ring positions, bit N is the high crosspoint buffer and bit N+1 is the high transit buffer. At most one bit is set. `sel_valid` is 1 exactly when one bit is set, and `sel_class` is 1 for a high grant and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hi_xp_req | input | 1 | Local high crosspoint buffer has a cell |
| hi_tb_req | input | 1 | High transit buffer has a cell |
| lo_xp_req | input | 1 | Local low crosspoint buffer has a cell |
| lo_vq_req | input | N-1 | Low transit buffer virtual queues that are not empty |
| dn_hi_full | input | 1 | Downstream high transit buffer nearly full |
| dn_lo_full | input | 1 | Downstream low transit buffer nearly full |
| sel_valid | output | 1 | A cell is granted this cycle |
| sel_class | output | 1 | 1 for a high grant, 0 for a low grant |
| sel_onehot | output | N+2 | One-hot grant vector |

## Verification
The bench builds the selector with N=4 and AGE_W=3. This gives a ring of four positions, so every pointer value and every wrap-around is visited many times. It also lets a waiting-time counter reach its ceiling of 7 within a few cycles. All 256 combinations of the eight request and backpressure inputs are applied in several shuffled orders and with varied hold lengths. A cycle-level model of the counters and the pointer predicts each grant. Directed sequences cover the reset state, the ring advancing and wrapping, and a saturation case where a counter that wrapped instead of stopping would change the winner.

// File: rtl/xs_sel_pkg.sv
package xs_sel_pkg;

    typedef enum logic {
        CLS_LOW  = 1'b0,
        CLS_HIGH = 1'b1
    } sel_cls_e;

    // saturating increment used by the high-class age counters
    function automatic logic [15:0] sat_inc(input logic [15:0] v, input logic [15:0] vmax);
        return (v >= vmax) ? vmax : v + 16'd1;
    endfunction

endpackage

// File: rtl/xs_hi_age_arb.sv
module xs_hi_age_arb #(
    parameter int AGE_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_xp,
    input  logic req_tb,
    input  logic allow,
    output logic gnt_xp,
    output logic gnt_tb
);
    import xs_sel_pkg::*;

    localparam logic [AGE_W-1:0] AGE_MAX = '1;

    typedef struct packed {
        logic [AGE_W-1:0] xp;
        logic [AGE_W-1:0] tb;
    } age_s;

    age_s st_q, st_d;

    always_comb begin
        logic tb_older;
        tb_older = (st_q.tb >= st_q.xp);
        gnt_tb   = allow && req_tb && (!req_xp || tb_older);
        gnt_xp   = allow && req_xp && (!req_tb || !tb_older);

        st_d = st_q;
        if (!req_xp || gnt_xp)
            st_d.xp = '0;
        else
            st_d.xp = AGE_W'(sat_inc(16'(st_q.xp), 16'(AGE_MAX)));
        if (!req_tb || gnt_tb)
            st_d.tb = '0;
        else
            st_d.tb = AGE_W'(sat_inc(16'(st_q.tb), 16'(AGE_MAX)));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_AGE_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.xp == AGE_MAX && req_xp && !gnt_xp) |=> (st_q.xp == AGE_MAX)); // R6
    AST_AGE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_tb |=> (st_q.tb == '0)); // R6
    AST_OLDER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_xp && req_tb) |-> (st_q.xp > st_q.tb)); // R5
    AST_SINGLE_HI: assert property (@(posedge clk) disable iff (!rst_n)
        !(gnt_xp && gnt_tb)); // R9

endmodule

// File: rtl/xs_rr_ring.sv
module xs_rr_ring #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic         en,
    output logic [N-1:0] gnt
);
    localparam int PW = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        logic [PW-1:0] ptr;
    } ring_s;

    ring_s st_q, st_d;
    logic  adv;

    always_comb begin
        logic          found;
        logic [PW-1:0] win;
        found = 1'b0;
        win   = '0;
        for (int k = 0; k < N; k++) begin
            int idx;
            idx = (int'(st_q.ptr) + k) % N;
            if (!found && req[idx]) begin
                found = 1'b1;
                win   = PW'(idx);
            end
        end
        adv  = en && found;
        gnt  = '0;
        st_d = st_q;
        if (adv) begin
            gnt[win] = 1'b1;
            st_d.ptr = (int'(win) == N - 1) ? '0 : win + PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(st_q.ptr)); // R8
    AST_GNT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0); // R7
    AST_LO_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt)); // R9

endmodule

// File: rtl/xp_cell_selector.sv
module xp_cell_selector #(
    parameter int N     = 8,
    parameter int AGE_W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           hi_xp_req,
    input  logic           hi_tb_req,
    input  logic           lo_xp_req,
    input  logic [N-2:0]   lo_vq_req,
    input  logic           dn_hi_full,
    input  logic           dn_lo_full,
    output logic           sel_valid,
    output logic           sel_class,
    output logic [N+1:0]   sel_onehot
);
    import xs_sel_pkg::*;

    logic         hi_any;
    logic         hi_allow;
    logic         lo_allow;
    logic         g_hi_xp;
    logic         g_hi_tb;
    logic [N-1:0] lo_req;
    logic [N-1:0] g_lo;

    always_comb begin
        hi_any   = hi_xp_req || hi_tb_req;
        hi_allow = !dn_hi_full;
        lo_allow = !dn_hi_full && !dn_lo_full && !hi_any;
        lo_req   = {lo_vq_req, lo_xp_req};
    end

    xs_hi_age_arb #(.AGE_W(AGE_W)) u_hi (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_xp (hi_xp_req),
        .req_tb (hi_tb_req),
        .allow  (hi_allow),
        .gnt_xp (g_hi_xp),
        .gnt_tb (g_hi_tb)
    );

    xs_rr_ring #(.N(N)) u_ring (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (lo_req),
        .en    (lo_allow),
        .gnt   (g_lo)
    );

    always_comb begin
        sel_onehot = {g_hi_tb, g_hi_xp, g_lo};
        sel_valid  = |sel_onehot;
        sel_class  = (g_hi_tb || g_hi_xp) ? CLS_HIGH : CLS_LOW;
    end

    AST_HI_STALL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        dn_hi_full |-> !sel_valid); // R2
    AST_NO_LO_UNDER_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_xp_req || hi_tb_req) |-> (g_lo == '0)); // R3
    AST_LO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        dn_lo_full |-> (g_lo == '0)); // R4
    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_onehot) && (sel_valid == ($countones(sel_onehot) == 1))); // R9

endmodule

// File: tb/xp_cell_selector_tb.sv
`timescale 1ns/1ps
module xp_cell_selector_tb;
    localparam int N     = 4;
    localparam int AGE_W = 3;
    localparam int AMAX  = (1 << AGE_W) - 1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           hi_xp_req = 1'b0, hi_tb_req = 1'b0, lo_xp_req = 1'b0;
    logic [N-2:0]   lo_vq_req = '0;
    logic           dn_hi_full = 1'b0, dn_lo_full = 1'b0;
    logic           sel_valid, sel_class;
    logic [N+1:0]   sel_onehot;

    int checks = 0;
    int errors = 0;
    int m_axp = 0, m_atb = 0, m_ptr = 0;

    always #2 clk = ~clk;

    xp_cell_selector #(.N(N), .AGE_W(AGE_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .hi_xp_req(hi_xp_req), .hi_tb_req(hi_tb_req),
        .lo_xp_req(lo_xp_req), .lo_vq_req(lo_vq_req),
        .dn_hi_full(dn_hi_full), .dn_lo_full(dn_lo_full),
        .sel_valid(sel_valid), .sel_class(sel_class), .sel_onehot(sel_onehot)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // pattern bits: 0 hi_xp, 1 hi_tb, 2 lo_xp, 5:3 vq, 6 dn_lo_full, 7 dn_hi_full
    task automatic step(input int pat, input string tag_in);
        int    exp_oh;
        int    win;
        string tag;
        bit    hx, ht, lx, nl, nh;
        int    lreq;
        hx = pat[0]; ht = pat[1]; lx = pat[2]; nl = pat[6]; nh = pat[7];
        lreq = ((pat >> 3) & 7) << 1 | int'(lx);
        hi_xp_req = hx; hi_tb_req = ht; lo_xp_req = lx;
        lo_vq_req = 3'((pat >> 3) & 7);
        dn_lo_full = nl; dn_hi_full = nh;
        #1;
        exp_oh = 0; win = -1;
        if (!nh) begin
            if (ht && (!hx || m_atb >= m_axp)) exp_oh = 1 << (N + 1);
            else if (hx) exp_oh = 1 << N;
            else if (!nl) begin
                for (int k = 0; k < N; k++) begin
                    int idx;
                    idx = (m_ptr + k) % N;
                    if (win < 0 && lreq[idx]) win = idx;
                end
                if (win >= 0) exp_oh = 1 << win;
            end
        end
        if (tag_in != "") tag = tag_in;
        else if (nh) tag = "R2";
        else if (hx && ht) tag = "R5";
        else if (hx || ht) tag = "R3";
        else if (nl) tag = "R4";
        else tag = "R7";
        check({tag, " onehot"}, int'(sel_onehot), exp_oh);
        check({tag, " R9 valid"}, int'(sel_valid), int'(exp_oh != 0));
        check({tag, " R9 class"}, int'(sel_class), int'(exp_oh >= (1 << N)));
        // model next state (R6 ages, R8 pointer)
        if (!hx || exp_oh == (1 << N)) m_axp = 0;
        else m_axp = (m_axp >= AMAX) ? AMAX : m_axp + 1;
        if (!ht || exp_oh == (1 << (N + 1))) m_atb = 0;
        else m_atb = (m_atb >= AMAX) ? AMAX : m_atb + 1;
        if (win >= 0) m_ptr = (win + 1) % N;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R1 reset valid", int'(sel_valid), 0);
        check("R1 reset onehot", int'(sel_onehot), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        step(8'h00, "R1 idle");
        step(8'h3C, "R1 first lo");      // all low requests: position 0 wins
        step(8'h3C, "R8 advance");
        step(8'h3C, "R8 advance");
        step(8'h3C, "R8 wrap");
        step(8'h3C, "R8 wrapped");
        step(8'h7C, "R4 hold ptr");
        step(8'h3C, "R8 after hold");
        step(8'h7D, "R4 hi passes");
        // R6 saturation: xp waits 12 cycles alone, tb joins for 5, then release
        for (int i = 0; i < 12; i++) step(8'h81, "R6 xp wait");
        for (int i = 0; i < 5; i++) step(8'h83, "R6 both wait");
        step(8'h03, "R6 saturated xp wins");
        step(8'h03, "R5 tb next");
        // near-exhaustive sweep over all input patterns
        for (int pass = 0; pass < 6; pass++) begin
            for (int i = 0; i < 256; i++) begin
                int pat;
                pat = (i * 37 + pass * 91) & 255;
                if (pass % 2 == 1) pat = pat & 8'h7F;
                for (int r = 0; r <= (i + pass) % 4; r++) step(pat, "");
            end
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule